// File: doc/BRIEF.md
# Secondary Bus Reset and Mode Sequencer

This block governs when the secondary side of a PCI/PCI-X bridge leaves reset. It holds the secondary reset low while the primary reset is active or while the bridge-control secondary-reset bit is set. It also holds it low until an external clock-stable indication arrives. After that it decodes the secondary bus mode from two sense inputs and drives the matching initialization pattern for a programmable number of clocks on each side of the release. Before release it briefly takes control of the capability-sense network.

When the secondary reset is released, the block latches a driver impedance choice for the secondary interface. Only the fastest PCI-X mode selects point-to-point drivers; every other mode selects multi-point drivers. The primary interface choice is latched from the pattern seen on the primary side on the first clock after the primary reset is removed.

The clock-stable input and the sense inputs are resynchronized before use. A clock-stable input that is tied high makes the sequence run without waiting. If clock-stable drops after it has been seen, the sequence does not restart. The drop can instead be reported on a sticky error flag.

Top module: `secrst_seq`

## Requirements
- R1: `sec_rst_n` is 0 while `pri_rst_n` is 0. It rises only after `pri_rst_n` is 1, `sec_rst_ctl` is 0 and the synchronized `clk_stable` has been seen high.
- R2: `cap_drv_en` is 0 for as long as the synchronized `clk_stable` has not been seen high in the current reset. It is 1 only during the pre-release pattern phase, while `sec_rst_n` is 0.
- R3: `clk_stable` is applied while the block waits. The synchronizer and FSM then see it on clock edge SYNC_STAGES after it is applied, counted from 0. That edge starts the pre-release phase. `sec_rst_n` rises on edge SYNC_STAGES+PRE_CLKS.
- R4: With `clk_stable` already high, release of `pri_rst_n` gives the same timing as R3, measured from the release.
- R5: The mode is latched when the pre-release phase starts, and the mode code is driven on `init_pat`. The codes are: `cap_sense`=00 gives 3'b000 (conventional PCI); `cap_sense`=01 gives 3'b001 (PCI-X 66); `cap_sense[1]`=1 with `sel100_sense`=1 gives 3'b010 (PCI-X 100); `cap_sense[1]`=1 with `sel100_sense`=0 gives 3'b011 (PCI-X 133). `init_pat` is 0 whenever `pat_oe` is 0.
- R6: `pat_oe` is 1 for exactly PRE_CLKS clocks before `sec_rst_n` rises and POST_CLKS clocks after it, and `init_pat` is constant in that window.
- R7: `sec_drv_p2p` is updated at the rise of `sec_rst_n`. It is 1 exactly when the latched mode is 3'b011. Later changes on the sense inputs do not alter it.
- R8: `pri_drv_p2p` takes the value (`pri_pat` == 3'b011) on the first clock after `pri_rst_n` rises. Later changes of `pri_pat` are ignored.
- R9: A fall of `clk_stable` after it has been seen, but before release, does not restart or delay the sequence. It sets `stable_drop_err`, which is cleared one clock after `sec_rst_ctl` forces the sequence back into reset.
- R10: Setting `sec_rst_ctl` drives `sec_rst_n` low after the next clock edge. Once it is cleared, the sequence restarts: the edge after clearing leaves the hold state, and the pre-release phase starts on the following edge if `clk_stable` is high.
- R11: In reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| pri_rst_n | input | 1 | Primary bus reset, active low, asynchronous |
| sec_rst_ctl | input | 1 | Bridge-control secondary-reset bit, 1 holds the secondary bus in reset |
| clk_stable | input | 1 | External secondary clock-stable indication |
| sel100_sense | input | 1 | 100 MHz select sense |
| cap_sense | input | 2 | Digitized capability sense: 00 PCI, 01 PCI-X 66, 1x PCI-X 133 capable |
| pri_pat | input | 3 | Mode pattern received on the primary side |
| sec_rst_n | output | 1 | Secondary bus reset, active low |
| init_pat | output | 3 | Secondary mode initialization pattern |
| pat_oe | output | 1 | Pattern drive enable |
| cap_drv_en | output | 1 | Capability-network drive enable |
| pri_drv_p2p | output | 1 | Primary drivers: 1 point-to-point (40 ohm), 0 multi-point (20 ohm) |
| sec_drv_p2p | output | 1 | Secondary drivers: 1 point-to-point (40 ohm), 0 multi-point (20 ohm) |
| stable_drop_err | output | 1 | Sticky flag for a clock-stable drop after it was seen |

## Verification
The bench sweeps all eight combinations of the sense inputs. Each run alternates between a tied-high clock-stable and a late handshake, so a wrong decode row, or a release that fails to wait for the handshake, shows up as a wrong pattern or an early reset edge. Every clock of the pattern window is compared against an arithmetic schedule. An off-by-one in either counter, or capability drive that starts before the handshake, is caught at the clock where it occurs. The bench drops clock-stable in the middle of the pre-release phase to catch a design that restarts or stalls. It changes the sense and primary-pattern inputs after the latch points to catch impedance selects that follow live inputs. Re-asserting the control bit tests that the sequence restarts with the new mode.

// File: rtl/secrst_pkg.sv
package secrst_pkg;

   // Secondary bus mode code, driven as the initialization pattern
   typedef enum logic [2:0] {
      MODE_PCI  = 3'b000,
      MODE_X66  = 3'b001,
      MODE_X100 = 3'b010,
      MODE_X133 = 3'b011
   } bus_mode_e;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_WAIT,
      ST_SETUP,
      ST_POST,
      ST_DONE
   } seq_state_e;

   // Fixed decode of the capability and 100 MHz select senses
   function automatic bus_mode_e decode_mode(input logic [1:0] cap, input logic sel100);
      if (cap[1])
         return sel100 ? MODE_X100 : MODE_X133;
      else if (cap[0])
         return MODE_X66;
      else
         return MODE_PCI;
   endfunction

   // Only the fastest PCI-X mode gets point-to-point drivers
   function automatic logic wants_p2p(input logic [2:0] code);
      return code == MODE_X133;
   endfunction

endpackage

// File: rtl/secrst_sync.sv
module secrst_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/secrst_fsm.sv
module secrst_fsm
   import secrst_pkg::*;
#(
   parameter int PRE_CLKS    = 4,
   parameter int POST_CLKS   = 4,
   parameter bit REPORT_DROP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_req,
   input  logic       stable_s,
   input  logic [1:0] cap_s,
   input  logic       sel_s,
   output logic       sec_rst_n,
   output logic       pat_oe,
   output logic       cap_drv_en,
   output logic       release_pulse,
   output bus_mode_e  mode,
   output logic       drop_err
);

   localparam int CNT_MAX = (PRE_CLKS > POST_CLKS) ? PRE_CLKS : POST_CLKS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CLKS - 1);
   localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_CLKS - 1);

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HOLD;
         cnt   <= '0;
         mode  <= MODE_PCI;
      end else if (hold_req) begin
         state <= ST_HOLD;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_HOLD: state <= ST_WAIT;
            ST_WAIT: begin
               if (stable_s) begin
                  state <= ST_SETUP;
                  cnt   <= '0;
                  mode  <= decode_mode(cap_s, sel_s);
               end
            end
            ST_SETUP: begin
               if (cnt == PRE_LAST) begin
                  state <= ST_POST;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_POST: begin
               if (cnt == POST_LAST) begin
                  state <= ST_DONE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: state <= ST_DONE;
            default: state <= ST_HOLD;
         endcase
      end
   end

   assign sec_rst_n     = (state == ST_POST) || (state == ST_DONE);
   assign pat_oe        = (state == ST_SETUP) || (state == ST_POST);
   assign cap_drv_en    = (state == ST_SETUP);
   assign release_pulse = (state == ST_SETUP) && (cnt == PRE_LAST) && !hold_req;

   generate
      if (REPORT_DROP) begin : g_drop_flag
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err_q <= 1'b0;
            else if (state == ST_HOLD)
               err_q <= 1'b0;
            else if ((state == ST_SETUP) && !stable_s)
               err_q <= 1'b1;
         end
         assign drop_err = err_q;
      end else begin : g_drop_ignore
         assign drop_err = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/secrst_imp.sv
module secrst_imp
   import secrst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] pri_pat,
   input  logic       sec_release,
   input  logic [2:0] sec_mode,
   output logic       pri_p2p,
   output logic       sec_p2p
);

   logic pri_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_taken <= 1'b0;
         pri_p2p   <= 1'b0;
         sec_p2p   <= 1'b0;
      end else begin
         if (!pri_taken) begin
            pri_taken <= 1'b1;
            pri_p2p   <= wants_p2p(pri_pat);
         end
         if (sec_release)
            sec_p2p <= wants_p2p(sec_mode);
      end
   end

endmodule

// File: rtl/secrst_seq.sv
module secrst_seq
   import secrst_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_CLKS    = 4,
   parameter int POST_CLKS   = 4,
   parameter bit REPORT_DROP = 1'b1
) (
   input  logic       clk,
   input  logic       pri_rst_n,
   input  logic       sec_rst_ctl,
   input  logic       clk_stable,
   input  logic       sel100_sense,
   input  logic [1:0] cap_sense,
   input  logic [2:0] pri_pat,
   output logic       sec_rst_n,
   output logic [2:0] init_pat,
   output logic       pat_oe,
   output logic       cap_drv_en,
   output logic       pri_drv_p2p,
   output logic       sec_drv_p2p,
   output logic       stable_drop_err
);

   localparam int SENSE_W = 4;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PRE_CLKS < 1) begin : g_bad_pre
         $error("PRE_CLKS must be at least 1");
      end
      if (POST_CLKS < 1) begin : g_bad_post
         $error("POST_CLKS must be at least 1");
      end
   endgenerate

   logic [SENSE_W-1:0] sense_raw, sense_s;
   logic               release_pulse;
   bus_mode_e          mode;

   assign sense_raw = {cap_sense, sel100_sense, clk_stable};

   secrst_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (pri_rst_n),
      .d     (sense_raw),
      .q     (sense_s)
   );

   secrst_fsm #(
      .PRE_CLKS    (PRE_CLKS),
      .POST_CLKS   (POST_CLKS),
      .REPORT_DROP (REPORT_DROP)
   ) fsm_i (
      .clk           (clk),
      .rst_n         (pri_rst_n),
      .hold_req      (sec_rst_ctl),
      .stable_s      (sense_s[0]),
      .cap_s         (sense_s[3:2]),
      .sel_s         (sense_s[1]),
      .sec_rst_n     (sec_rst_n),
      .pat_oe        (pat_oe),
      .cap_drv_en    (cap_drv_en),
      .release_pulse (release_pulse),
      .mode          (mode),
      .drop_err      (stable_drop_err)
   );

   secrst_imp imp_i (
      .clk         (clk),
      .rst_n       (pri_rst_n),
      .pri_pat     (pri_pat),
      .sec_release (release_pulse),
      .sec_mode    (mode),
      .pri_p2p     (pri_drv_p2p),
      .sec_p2p     (sec_drv_p2p)
   );

   assign init_pat = pat_oe ? mode : 3'b000;

endmodule

module secrst_seq_chk (
   input logic       clk,
   input logic       pri_rst_n,
   input logic       sec_rst_ctl,
   input logic       sec_rst_n,
   input logic [2:0] init_pat,
   input logic       pat_oe,
   input logic       cap_drv_en,
   input logic       sec_drv_p2p,
   input logic       stable_drop_err
);

   // R10
   ctl_forces_reset_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      sec_rst_ctl |=> !sec_rst_n);

   // R2
   cap_before_release_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      cap_drv_en |-> (!sec_rst_n && pat_oe));

   // R6
   pat_steady_at_release_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      $rose(sec_rst_n) |-> (pat_oe && $stable(init_pat)));

   // R5
   pat_idle_zero_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      !pat_oe |-> (init_pat == 3'b000));

   // R7
   sec_imp_match_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      $rose(sec_rst_n) |-> (sec_drv_p2p == (init_pat == 3'b011)));

   // R9
   drop_before_release_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      $rose(stable_drop_err) |-> !$past(sec_rst_n));

endmodule

bind secrst_seq secrst_seq_chk chk_i (
   .clk             (clk),
   .pri_rst_n       (pri_rst_n),
   .sec_rst_ctl     (sec_rst_ctl),
   .sec_rst_n       (sec_rst_n),
   .init_pat        (init_pat),
   .pat_oe          (pat_oe),
   .cap_drv_en      (cap_drv_en),
   .sec_drv_p2p     (sec_drv_p2p),
   .stable_drop_err (stable_drop_err)
);

// File: tb/secrst_seq_tb_top.sv
module secrst_seq_tb_top;

   localparam int S    = 2;
   localparam int PRE  = 3;
   localparam int POST = 2;

   logic       clk = 1'b0;
   logic       pri_rst_n = 1'b0;
   logic       sec_rst_ctl = 1'b0;
   logic       clk_stable = 1'b0;
   logic       sel100_sense = 1'b0;
   logic [1:0] cap_sense = 2'b00;
   logic [2:0] pri_pat = 3'b000;
   logic       sec_rst_n;
   logic [2:0] init_pat;
   logic       pat_oe;
   logic       cap_drv_en;
   logic       pri_drv_p2p;
   logic       sec_drv_p2p;
   logic       stable_drop_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   secrst_seq #(
      .SYNC_STAGES (S),
      .PRE_CLKS    (PRE),
      .POST_CLKS   (POST),
      .REPORT_DROP (1'b1)
   ) dut_i (
      .clk             (clk),
      .pri_rst_n       (pri_rst_n),
      .sec_rst_ctl     (sec_rst_ctl),
      .clk_stable      (clk_stable),
      .sel100_sense    (sel100_sense),
      .cap_sense       (cap_sense),
      .pri_pat         (pri_pat),
      .sec_rst_n       (sec_rst_n),
      .init_pat        (init_pat),
      .pat_oe          (pat_oe),
      .cap_drv_en      (cap_drv_en),
      .pri_drv_p2p     (pri_drv_p2p),
      .sec_drv_p2p     (sec_drv_p2p),
      .stable_drop_err (stable_drop_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic int exp_mode(input int cap, input int sel);
      if (cap >= 2) return sel ? 2 : 3;
      return cap;
   endfunction

   // Walks the pattern window; s_edge is the edge index that starts the pre-release phase
   task automatic window(input int s_edge, input int m, input string rtag,
                         input int drop_at, input int new_pri);
      for (int k = 1; k <= s_edge + PRE + POST + 2; k++) begin
         int e_rst, e_oe, e_cap;
         step();
         e_rst = (k >= s_edge + PRE + 1) ? 1 : 0;
         e_oe  = (k >= s_edge + 1 && k <= s_edge + PRE + POST) ? 1 : 0;
         e_cap = (k >= s_edge + 1 && k <= s_edge + PRE) ? 1 : 0;
         chk(rtag, "sec_rst_n", int'(sec_rst_n), e_rst);
         chk("R6", "pat_oe", int'(pat_oe), e_oe);
         chk("R2", "cap_drv_en", int'(cap_drv_en), e_cap);
         chk("R5", "init_pat", int'(init_pat), e_oe ? m : 0);
         if (k == 1) pri_pat = 3'(new_pri);
         if (k == drop_at) clk_stable = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int idx = 0; idx < 8; idx++) begin
         int cap, sel, tied, m, m2;
         cap  = idx >> 1;
         sel  = idx & 1;
         tied = (idx ^ (idx >> 1)) & 1;
         m    = exp_mode(cap, sel);
         pri_rst_n    = 1'b0;
         sec_rst_ctl  = 1'b0;
         clk_stable   = tied[0];
         cap_sense    = 2'(cap);
         sel100_sense = sel[0];
         pri_pat      = 3'(idx);
         step(); step(); step();
         // R11: everything quiet during reset
         chk("R11", "sec_rst_n", int'(sec_rst_n), 0);
         chk("R11", "pat_oe", int'(pat_oe), 0);
         chk("R11", "cap_drv_en", int'(cap_drv_en), 0);
         chk("R11", "p2p", int'(pri_drv_p2p) + int'(sec_drv_p2p), 0);
         chk("R11", "stable_drop_err", int'(stable_drop_err), 0);
         chk("R1", "sec_rst_n in primary reset", int'(sec_rst_n), 0);
         pri_rst_n = 1'b1;
         if (tied != 0) begin
            window(S, m, "R4", 0, (idx == 3) ? 0 : 3);
         end else begin
            for (int w = 0; w < 6; w++) begin
               step();
               chk("R2", "cap_drv_en waiting", int'(cap_drv_en), 0);
               chk("R1", "sec_rst_n waiting", int'(sec_rst_n), 0);
               chk("R3", "pat_oe waiting", int'(pat_oe), 0);
            end
            clk_stable = 1'b1;
            window(S, m, "R3", 0, (idx == 3) ? 0 : 3);
         end
         chk("R7", "sec_drv_p2p", int'(sec_drv_p2p), (m == 3) ? 1 : 0);
         chk("R8", "pri_drv_p2p", int'(pri_drv_p2p), (idx == 3) ? 1 : 0);
         // flip senses after the latch point
         cap_sense    = ~cap_sense;
         sel100_sense = ~sel100_sense;
         m2 = exp_mode(3 - cap, 1 - sel);
         step(); step(); step(); step();
         chk("R7", "sec_drv_p2p after sense change", int'(sec_drv_p2p), (m == 3) ? 1 : 0);
         chk("R8", "pri_drv_p2p after pattern change", int'(pri_drv_p2p), (idx == 3) ? 1 : 0);
         // R10: control bit forces reset, then restarts with the new senses
         sec_rst_ctl = 1'b1;
         step();
         chk("R10", "sec_rst_n after ctl set", int'(sec_rst_n), 0);
         for (int w = 0; w < 3; w++) begin
            step();
            chk("R10", "held by ctl", int'(sec_rst_n) + int'(pat_oe) + int'(cap_drv_en), 0);
         end
         sec_rst_ctl = 1'b0;
         window(1, m2, "R10", 0, 3);
         chk("R7", "sec_drv_p2p after restart", int'(sec_drv_p2p), (m2 == 3) ? 1 : 0);
      end

      // R9: clock-stable drop during the pre-release phase
      pri_rst_n    = 1'b0;
      sec_rst_ctl  = 1'b0;
      clk_stable   = 1'b0;
      cap_sense    = 2'b10;
      sel100_sense = 1'b0;
      step(); step();
      pri_rst_n = 1'b1;
      step(); step(); step();
      chk("R9", "stable_drop_err before", int'(stable_drop_err), 0);
      clk_stable = 1'b1;
      window(S, 3, "R9", S + 1, 0);
      chk("R9", "stable_drop_err set", int'(stable_drop_err), 1);
      chk("R9", "sec_rst_n kept released", int'(sec_rst_n), 1);
      sec_rst_ctl = 1'b1;
      step(); step();
      chk("R9", "stable_drop_err cleared", int'(stable_drop_err), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule